// File: doc/BRIEF.md
# Processor-to-Backplane Bus Cycle Sequencer

This block turns the 64-bit bus cycles of a processor into data transfer cycles on an asynchronous backplane. At the start of a cycle the processor gives the direction, memory or I/O space, a code-fetch flag, the cache request and cache enable lines, and eight byte enables. The sequencer picks the address modifier and the transfer direction. It then drives the address strobe and the two data strobes, one step at a time. It waits for the addressed slave's acknowledge and for a separate console acknowledge, and it returns one ready pulse to the processor for each accepted beat.

A cacheable line fill or a cacheable memory write moves 32 bytes as four 64-bit beats. The processor never marks the last beat of a block, so an internal counter finds it. Every other access is a single beat. Operands are expected to be naturally aligned, so no cycle is split. If no slave answers within a parameterised number of clocks, a time-out accepts the beat with an error. The sequencer then flags a bus error and a non-maskable interrupt to the processor and abandons the rest of the cycle.

Top module: `bkpl_cycle_seq`

## Requirements
- R1: While reset is low and right after it, address strobe, both data strobes, ready, error and NMI are all low.
- R2: A cycle becomes a four-beat block when the cache request is high and either the access is a read with cache enable high, or a memory-space write. Any other cycle is exactly one beat.
- R3: The address modifier is 0x0C for a four-beat block and for a single access with all eight byte enables set. Any other single access uses 0x0E if the code-fetch flag is set and 0x0D if it is not.
- R4: In a single access, data strobe bit 1 is driven when any of byte enables 7..4 is set, and bit 0 when any of byte enables 3..0 is set. A block drives both bits on every beat.
- R5: From one clock to the next, at most one of two things changes: the address strobe, or the data strobe pair taken as a whole. The modifier and direction are set one clock before the address strobe rises, and the address strobe rises one clock before the first data strobe.
- R6: The address strobe rises once per cycle, stays high through every beat, and falls on the clock after the final ready pulse.
- R7: Ready is a one-clock pulse, issued once per accepted beat, in the clock when the data strobes are low again.
- R8: No beat is accepted without the console acknowledge, even when the slave has acknowledged or the time-out has expired.
- R9: If the slave does not acknowledge, the data strobes stay high for TO_CYCLES+1 clocks and the beat is then accepted (once the console acknowledges). Ready, error and NMI pulse together in one clock, and any remaining beats of a block are dropped.
- R10: Between beats of a block, the data strobes are not driven again until both the slave acknowledge and the console acknowledge are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_ads | input | 1 | One-clock cycle start pulse from the processor |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_mem | input | 1 | 1 = memory space, 0 = I/O space |
| cpu_code | input | 1 | 1 = instruction fetch |
| cpu_cache_req | input | 1 | Processor requests a cacheable transfer |
| cpu_cache_en | input | 1 | System grants cacheability for a read |
| cpu_be | input | BE_W | Byte enables of the aligned 64-bit word |
| cpu_rdy | output | 1 | Beat complete pulse to the processor |
| cpu_err | output | 1 | Bus error pulse, coincident with ready |
| cpu_nmi | output | 1 | Non-maskable interrupt pulse on time-out |
| bp_am | output | 6 | Backplane address modifier |
| bp_write | output | 1 | Backplane transfer direction, 1 = write |
| bp_as | output | 1 | Address strobe, active high |
| bp_ds | output | 2 | Data strobe pair, active high |
| bp_ack | input | 1 | Slave data acknowledge, active high |
| con_ack | input | 1 | Console acknowledge, active high |

## Verification
The properties assume that both acknowledges are synchronous to the clock and that the console acknowledge is the one seen at the edge where a beat closes. They also assume a new start pulse comes only once the previous cycle has released the address strobe. The bench keeps to this. It issues each start pulse only after the address strobe has dropped. Its behavioural slave and console register their acknowledges from the data strobes, with a configurable hold after release, so acknowledges stay high across beat gaps. Slave suppression and a delayed console enable give the time-out and console-hold cases.

// File: rtl/bcs_pkg.sv
// Shared types for the backplane cycle sequencer.
// Assumes: address modifier codes are six bits wide.
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // no cycle, waiting for a start pulse
        ST_ADR,    // modifier and direction driven, strobes low
        ST_AS,     // address strobe raised
        ST_DATA,   // data strobes raised, waiting for acknowledge
        ST_REL,    // strobes dropped, ready pulse to the processor
        ST_GAP     // between beats, waiting for acknowledges to clear
    } bcs_state_t;

    localparam logic [5:0] AM_BLOCK64 = 6'h0C;
    localparam logic [5:0] AM_SUP_DAT = 6'h0D;
    localparam logic [5:0] AM_SUP_PRG = 6'h0E;

endpackage

// File: rtl/bcs_timeout.sv
// Acknowledge time-out counter.
// Counts clocks while 'run' is high, clears while it is low, saturates at
// TO_CYCLES and reports expiry there. Assumes TO_CYCLES >= 1.
module bcs_timeout #(
    parameter int TO_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int              CW    = $clog2(TO_CYCLES + 1);
    localparam logic [CW-1:0]   LIMIT = CW'(TO_CYCLES);

    logic [CW-1:0] cnt;

    // Count clocks of one strobe assertion, restart when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIMIT);
endmodule

// File: rtl/bcs_beat_cnt.sv
// Beat counter for block transfers.
// Loads the number of remaining beats at cycle start and steps down once per
// accepted beat. 'last' is high while the current beat is the final one.
// Assumes BEATS >= 1.
module bcs_beat_cnt #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic burst,
    input  logic step,
    output logic last
);
    localparam int            BW    = $clog2(BEATS + 1);
    localparam logic [BW-1:0] FIRST = BW'(BEATS - 1);

    logic [BW-1:0] left;

    // Track how many beats follow the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (load) begin
            left <= burst ? FIRST : '0;
        end else if (step && left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign last = (left == '0);
endmodule

// File: rtl/bkpl_cycle_seq.sv
// Processor-to-backplane bus cycle sequencer (top).
// Runs one processor bus cycle as one or BEATS backplane beats, changing at
// most one of {address strobe, data strobe pair} per clock. Assumes aligned
// operands, acknowledges synchronous to clk, and a start pulse only while idle.
module bkpl_cycle_seq
    import bcs_pkg::*;
#(
    parameter int TO_CYCLES = 64,
    parameter int BEATS     = 4,
    parameter int BE_W      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_ads,
    input  logic            cpu_wr,
    input  logic            cpu_mem,
    input  logic            cpu_code,
    input  logic            cpu_cache_req,
    input  logic            cpu_cache_en,
    input  logic [BE_W-1:0] cpu_be,
    output logic            cpu_rdy,
    output logic            cpu_err,
    output logic            cpu_nmi,
    output logic [5:0]      bp_am,
    output logic            bp_write,
    output logic            bp_as,
    output logic [1:0]      bp_ds,
    input  logic            bp_ack,
    input  logic            con_ack
);
    localparam int HALF = BE_W / 2;

    bcs_state_t state, state_nx;
    logic       wr_q, err_q;
    logic [5:0] am_q;
    logic [1:0] ds_mask_q;
    logic       start, want_burst, full_word, accept, last, expired;
    logic [5:0] am_sel;
    logic [1:0] ds_sel;

    // Decode cycle attributes from the processor's start-of-cycle inputs.
    always_comb begin
        start      = (state == ST_IDLE) && cpu_ads;
        want_burst = cpu_cache_req && ((!cpu_wr && cpu_cache_en) || (cpu_wr && cpu_mem));
        full_word  = &cpu_be;
        if (want_burst || full_word) begin
            am_sel = AM_BLOCK64;
        end else if (cpu_code) begin
            am_sel = AM_SUP_PRG;
        end else begin
            am_sel = AM_SUP_DAT;
        end
        if (want_burst) begin
            ds_sel = 2'b11;
        end else begin
            ds_sel = {|cpu_be[BE_W-1:HALF], |cpu_be[HALF-1:0]};
        end
    end

    // Beat acceptance: slave or time-out, always with the console.
    assign accept = (bp_ack || expired) && con_ack;

    // Next-state logic; each step moves one strobe only.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cpu_ads) state_nx = ST_ADR;
            ST_ADR:  state_nx = ST_AS;
            ST_AS:   state_nx = ST_DATA;
            ST_DATA: if (accept) state_nx = ST_REL;
            ST_REL:  state_nx = (last || err_q) ? ST_IDLE : ST_GAP;
            ST_GAP:  if (!bp_ack && !con_ack) state_nx = ST_DATA;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture cycle attributes at start; record time-out at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            am_q      <= AM_SUP_DAT;
            ds_mask_q <= 2'b00;
            err_q     <= 1'b0;
        end else begin
            if (start) begin
                wr_q      <= cpu_wr;
                am_q      <= am_sel;
                ds_mask_q <= ds_sel;
                err_q     <= 1'b0;
            end
            if (state == ST_DATA && accept) begin
                err_q <= !bp_ack;
            end
        end
    end

    bcs_timeout #(.TO_CYCLES(TO_CYCLES)) u_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_DATA),
        .expired (expired)
    );

    bcs_beat_cnt #(.BEATS(BEATS)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .burst (want_burst),
        .step  (state == ST_REL),
        .last  (last)
    );

    // Backplane and processor outputs decoded from the state.
    always_comb begin
        bp_as    = (state == ST_AS) || (state == ST_DATA) ||
                   (state == ST_REL) || (state == ST_GAP);
        bp_ds    = (state == ST_DATA) ? ds_mask_q : 2'b00;
        bp_am    = am_q;
        bp_write = wr_q;
        cpu_rdy  = (state == ST_REL);
        cpu_err  = (state == ST_REL) && err_q;
        cpu_nmi  = (state == ST_REL) && err_q;
    end
endmodule

// File: rtl/bcs_chk.sv
// Property checker for the backplane cycle sequencer, bound to the top.
// Observes ports only; assumes acknowledges synchronous to clk.
module bcs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bp_as,
    input logic [1:0] bp_ds,
    input logic       cpu_rdy,
    input logic       cpu_err,
    input logic       cpu_nmi,
    input logic       con_ack
);
    // R5
    one_strobe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({bp_as ^ $past(bp_as), (|bp_ds) ^ $past(|bp_ds)}) <= 1);

    // R7
    rdy_single_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |=> !cpu_rdy);

    // R7
    rdy_strobes_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |-> (bp_ds == 2'b00) && bp_as);

    // R8
    rdy_needs_console_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |-> $past(con_ack));

    // R9
    err_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> cpu_rdy && cpu_nmi);

    // R9
    nmi_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_nmi |-> cpu_err);

    // R6
    as_drop_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bp_as) |-> $past(cpu_rdy));
endmodule

bind bkpl_cycle_seq bcs_chk u_bcs_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bp_as   (bp_as),
    .bp_ds   (bp_ds),
    .cpu_rdy (cpu_rdy),
    .cpu_err (cpu_err),
    .cpu_nmi (cpu_nmi),
    .con_ack (con_ack)
);

// File: tb/tb_bkpl_cycle_seq.sv
// Directed bench for the backplane cycle sequencer.
module tb_bkpl_cycle_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TO_C       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_ads = 1'b0, cpu_wr = 1'b0, cpu_mem = 1'b0, cpu_code = 1'b0;
    logic       cpu_cache_req = 1'b0, cpu_cache_en = 1'b0;
    logic [7:0] cpu_be = 8'h00;
    logic       cpu_rdy, cpu_err, cpu_nmi, bp_write, bp_as;
    logic [5:0] bp_am;
    logic [1:0] bp_ds;
    logic       bp_ack, con_ack;

    logic       slv_en = 1'b1, con_en = 1'b1;
    int         slv_hold = 0;
    int         hcnt;

    int checks = 0, fails = 0;
    int r_rdy, r_err, r_nmi, r_ds_rise, r_as_rise, r_maxrun, r_step_bad;
    int r_gap_bad, r_early_rdy, r_hold_ds, r_am, r_am_pre, r_ds_or;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpl_cycle_seq #(.TO_CYCLES(TO_C), .BEATS(4), .BE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_ads(cpu_ads), .cpu_wr(cpu_wr),
        .cpu_mem(cpu_mem), .cpu_code(cpu_code), .cpu_cache_req(cpu_cache_req),
        .cpu_cache_en(cpu_cache_en), .cpu_be(cpu_be), .cpu_rdy(cpu_rdy),
        .cpu_err(cpu_err), .cpu_nmi(cpu_nmi), .bp_am(bp_am), .bp_write(bp_write),
        .bp_as(bp_as), .bp_ds(bp_ds), .bp_ack(bp_ack), .con_ack(con_ack)
    );

    // Behavioural slave and console: acknowledge strobes one clock later.
    always @(posedge clk) begin
        if (!rst_n) begin
            bp_ack <= 1'b0; hcnt <= 0; con_ack <= 1'b0;
        end else begin
            if (slv_en && (|bp_ds)) begin
                bp_ack <= 1'b1; hcnt <= slv_hold;
            end else if (hcnt != 0) begin
                hcnt <= hcnt - 1;
            end else begin
                bp_ack <= 1'b0;
            end
            con_ack <= con_en && (|bp_ds);
        end
    end

    // Watchdog: a hung run counts as one more failure.
    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Run one processor cycle; con_hold > 0 holds the console off that long.
    task automatic run_cycle(input bit wr, input bit mem, input bit code,
                             input bit creq, input bit cen, input logic [7:0] be,
                             input int con_hold);
        bit pas, pds, seen;
        int run;
        r_rdy = 0; r_err = 0; r_nmi = 0; r_ds_rise = 0; r_as_rise = 0;
        r_maxrun = 0; r_step_bad = 0; r_gap_bad = 0; r_early_rdy = 0;
        r_hold_ds = 0; r_am = -1; r_am_pre = -1; r_ds_or = 0;
        if (con_hold > 0) con_en = 1'b0;
        @(negedge clk);
        cpu_ads = 1'b1; cpu_wr = wr; cpu_mem = mem; cpu_code = code;
        cpu_cache_req = creq; cpu_cache_en = cen; cpu_be = be;
        @(negedge clk);
        cpu_ads = 1'b0;
        pas = 1'b0; pds = 1'b0; seen = 1'b0; run = 0;
        for (int n = 0; n < 3000; n++) begin
            if (!bp_as && !seen) r_am_pre = int'(bp_am);
            if (bp_as && !pas) begin r_as_rise++; r_am = int'(bp_am); end
            if ((|bp_ds) && !pds) begin
                r_ds_rise++;
                if (bp_ack || con_ack) r_gap_bad++;
                if (!pas) r_step_bad++;
            end
            if (int'(bp_as != pas) + int'((|bp_ds) != pds) > 1) r_step_bad++;
            if (|bp_ds) begin run++; if (run > r_maxrun) r_maxrun = run; end
            else run = 0;
            r_ds_or |= int'(bp_ds);
            if (cpu_rdy) r_rdy++;
            if (cpu_err) r_err++;
            if (cpu_nmi) r_nmi++;
            if (con_hold > 0 && n == con_hold) begin
                r_early_rdy = r_rdy;
                r_hold_ds = int'(|bp_ds);
                con_en = 1'b1;
            end
            if (bp_as) seen = 1'b1;
            if (seen && !bp_as) break;
            pas = bp_as; pds = |bp_ds;
            @(negedge clk);
        end
        con_en = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        // R1: all strobes and processor returns low in reset
        check(!bp_as && bp_ds == 0 && !cpu_rdy && !cpu_err && !cpu_nmi,
              "R1 outputs in reset", int'({bp_as, bp_ds, cpu_rdy, cpu_err, cpu_nmi}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bp_as && bp_ds == 0 && !cpu_rdy, "R1 outputs after reset",
              int'({bp_as, bp_ds, cpu_rdy}), 0);
    endtask

    task automatic t_burst_read;
        run_cycle(0, 1, 0, 1, 1, 8'hFF, 0);
        check(r_ds_rise == 4 && r_rdy == 4, "R2 line read beats", r_ds_rise * 10 + r_rdy, 44);
        check(r_am == 'h0C && r_am_pre == 'h0C, "R3 line read modifier", r_am, 'h0C);
        check(r_as_rise == 1, "R6 strobe held over line", r_as_rise, 1);
        check(r_step_bad == 0, "R5 one strobe change per clock", r_step_bad, 0);
        check(r_err == 0 && r_nmi == 0, "R7 no error on acked line", r_err + r_nmi, 0);
    endtask

    task automatic t_burst_write;
        slv_hold = 3;
        run_cycle(1, 1, 0, 1, 0, 8'hFF, 0);
        check(r_ds_rise == 4 && r_rdy == 4, "R2 line write beats", r_ds_rise * 10 + r_rdy, 44);
        check(r_gap_bad == 0, "R10 strobes wait for ack release", r_gap_bad, 0);
        check(bp_write == 1'b1, "R5 direction driven", int'(bp_write), 1);
        slv_hold = 0;
    endtask

    task automatic t_single_full;
        run_cycle(0, 1, 0, 1, 0, 8'hFF, 0);
        check(r_ds_rise == 1 && r_rdy == 1, "R2 uncached read one beat", r_ds_rise * 10 + r_rdy, 11);
        check(r_am == 'h0C, "R3 full word single modifier", r_am, 'h0C);
        check(r_ds_or == 3, "R4 full word strobes", r_ds_or, 3);
    endtask

    task automatic t_single_lo;
        run_cycle(1, 0, 0, 1, 1, 8'h0F, 0);
        check(r_ds_rise == 1, "R2 I/O write one beat", r_ds_rise, 1);
        check(r_am == 'h0D, "R3 data modifier", r_am, 'h0D);
        check(r_ds_or == 1, "R4 low half strobe", r_ds_or, 1);
    endtask

    task automatic t_single_code_hi;
        run_cycle(0, 1, 1, 0, 0, 8'hF0, 0);
        check(r_am == 'h0E, "R3 code modifier", r_am, 'h0E);
        check(r_ds_or == 2, "R4 high half strobe", r_ds_or, 2);
    endtask

    task automatic t_single_mid;
        run_cycle(0, 1, 0, 0, 0, 8'h18, 0);
        check(r_ds_or == 3 && r_am == 'h0D, "R4 straddling bytes", r_ds_or * 256 + r_am, 3 * 256 + 'h0D);
    endtask

    task automatic t_console_hold;
        run_cycle(0, 1, 0, 0, 0, 8'hFF, 40);
        check(r_early_rdy == 0 && r_hold_ds == 1, "R8 no beat without console",
              r_early_rdy * 10 + r_hold_ds, 1);
        check(r_rdy == 1 && r_err == 0, "R8 completes after console", r_rdy * 10 + r_err, 10);
    endtask

    task automatic t_timeout;
        slv_en = 1'b0;
        run_cycle(0, 1, 0, 1, 1, 8'hFF, 0);
        slv_en = 1'b1;
        check(r_maxrun == TO_C + 1, "R9 strobe length to time-out", r_maxrun, TO_C + 1);
        check(r_rdy == 1 && r_err == 1 && r_nmi == 1, "R9 error pulses",
              r_rdy * 100 + r_err * 10 + r_nmi, 111);
        check(r_ds_rise == 1, "R9 remaining beats dropped", r_ds_rise, 1);
        run_cycle(0, 1, 0, 1, 1, 8'hFF, 0);
        check(r_rdy == 4 && r_err == 0, "R9 clean cycle after time-out", r_rdy * 10 + r_err, 40);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_burst_read();
        t_burst_write();
        t_single_full();
        t_single_lo();
        t_single_code_hi();
        t_single_mid();
        t_console_hold();
        t_timeout();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule